// File: doc/BRIEF.md
# Board Control Register Block with Interrupt Aggregator

This block is a small memory-mapped control unit for a board. Software reaches it through a 32-bit register port with a 20-bit byte address inside a 1 MiB window. It stores eight plain read/write words: two LED data words, an LED control word, a switch word, three miscellaneous control words and one miscellaneous status word. Every other offset reads as zero and ignores writes.

The block also merges sixteen external level-sensitive interrupt lines into one active-high interrupt output. Each line passes through a two-flop synchronizer into a level register. A synchronized high level sets the matching pending bit only while that line's mask bit is enabled. Pending bits stay set until software rewrites the whole pending word. The output is the registered OR of pending AND mask.

Two card-slot status words report a fixed ready flag and an active-low card-detect flag. The card-detect flag follows interrupt lines 9 and 13. Software may change only the five low control bits of each slot word.

Top module: `board_ctrl_irq`

## Requirements
- R1: The words at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 store all 32 written bits, and a read returns the stored value.
- R2: A change on `irq_in` reaches the level register after two clock edges. A line that is high with its mask bit set raises `irq_out` on the fourth edge after the change and not before.
- R3: A synchronized high line whose mask bit is set sets its pending bit. A high line whose mask bit is clear leaves its pending bit unchanged. A line that falls does not clear its pending bit.
- R4: Writes to the mask word (offset 0xC0) and to the pending word (offset 0xD0) keep only the bits in 0x000FEEFF. Mask bits 8 and 12 therefore stay zero, so lines 8 and 12 can never latch.
- R5: `irq_out` is high exactly one cycle after the AND of pending and mask is non-zero. Software sets or clears pending bits by writing the full pending word, and such a write takes priority over latching in the same cycle.
- R6: Slot 0 (offset 0xE0) bit 5 reads 0 while synchronized line 9 is high and reads 1 while it is low. Slot 1 (offset 0xE4) bit 5 follows line 13 in the same way.
- R7: A write to a slot word changes only bits [4:0]. Bit 10 always reads 1, and bits [31:11] and [9:6] read 0.
- R8: After reset, both slot words read 0x00000420, `irq_out` is 0, and every other mapped word reads 0.
- R9: A read of an unmapped offset returns 0, and a write to an unmapped offset changes no mapped word.
- R10: Read data appears on `rsp_rdata` on the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_in | input | 16 | External level interrupt lines, asynchronous |
| irq_out | output | 1 | Combined active-high interrupt |

## Verification
The assertions assume that each request lasts exactly one cycle and that the address is stable while `req_valid` is high. The bench drives every request and every line change on the falling clock edge, holding each for one full cycle, so these assumptions hold. The latching assertions also assume that the level register changes only through the synchronizer. The bench keeps this true by holding each line change for several cycles before it reads status or checks the output.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 20;
  localparam int unsigned GP_NUM   = 8;
  localparam logic [DW-1:0] IRQ_WR_PAT = 32'h000F_EEFF;
  localparam logic [AW-1:0] OFF_MASK  = 20'h000C0;
  localparam logic [AW-1:0] OFF_PEND  = 20'h000D0;
  localparam logic [AW-1:0] OFF_SLOT0 = 20'h000E0;
  localparam logic [AW-1:0] OFF_SLOT1 = 20'h000E4;
  localparam int unsigned SLOT_CTL_W = 5;
  localparam int unsigned SLOT_CD_BIT = 5;
  localparam int unsigned SLOT_RDY_BIT = 10;

  // byte offset of general-purpose word idx
  function automatic logic [AW-1:0] gp_off(input int unsigned idx);
    case (idx)
      0: gp_off = 20'h00010;
      1: gp_off = 20'h00014;
      2: gp_off = 20'h00040;
      3: gp_off = 20'h00060;
      4: gp_off = 20'h00080;
      5: gp_off = 20'h00084;
      6: gp_off = 20'h00088;
      default: gp_off = 20'h00090;
    endcase
  endfunction

  function automatic logic addr_mapped(input logic [AW-1:0] a);
    logic hit;
    hit = (a == OFF_MASK) || (a == OFF_PEND) || (a == OFF_SLOT0) || (a == OFF_SLOT1);
    for (int unsigned i = 0; i < GP_NUM; i++) hit = hit || (a == gp_off(i));
    return hit;
  endfunction

  // next pending word: software write wins, otherwise sticky OR of masked levels
  function automatic logic [DW-1:0] pend_next(input logic [DW-1:0] pend,
                                              input logic [DW-1:0] lvl,
                                              input logic [DW-1:0] mask,
                                              input logic          sw_wr,
                                              input logic [DW-1:0] wdata);
    return sw_wr ? (wdata & IRQ_WR_PAT) : (pend | (lvl & mask));
  endfunction

  // slot status word from control bits and synchronized detect line
  function automatic logic [DW-1:0] slot_word(input logic [SLOT_CTL_W-1:0] ctl,
                                              input logic line_hi);
    logic [DW-1:0] w;
    w = '0;
    w[SLOT_CTL_W-1:0] = ctl;
    w[SLOT_CD_BIT]    = ~line_hi;
    w[SLOT_RDY_BIT]   = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        lvl_q  <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        lvl_q  <= meta_q;
      end
    end
    assign level_q[i] = lvl_q;
  end
endmodule

// File: rtl/bcr_irq_core.sv
module bcr_irq_core
  import bcr_pkg::*;
#(
  parameter int unsigned N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] level,
  input  logic             wr_mask,
  input  logic             wr_pend,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    mask_q,
  output logic [DW-1:0]    pend_q,
  output logic             irq_q
);
  logic [DW-1:0] level_ext;
  logic [DW-1:0] pend_d;
  logic          any_active;

  assign level_ext  = DW'(level);
  assign pend_d     = pend_next(pend_q, level_ext, mask_q, wr_pend, wdata);
  assign any_active = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata & IRQ_WR_PAT;
      pend_q <= pend_d;
      irq_q  <= any_active;
    end
  end
endmodule

// File: rtl/bcr_regs.sv
module bcr_regs
  import bcr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mask_q,
  input  logic [DW-1:0] pend_q,
  input  logic [1:0]    cd_line,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] gp_rd [GP_NUM];
  logic [DW-1:0] slot_rd [2];
  logic [DW-1:0] rd_val;

  for (genvar g = 0; g < GP_NUM; g++) begin : g_gp
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (wr && addr == gp_off(g))  q <= wdata;
    end
    assign gp_rd[g] = q;
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    localparam logic [AW-1:0] SOFF = (s == 0) ? OFF_SLOT0 : OFF_SLOT1;
    logic [SLOT_CTL_W-1:0] ctl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ctl_q <= '0;
      else if (wr && addr == SOFF) ctl_q <= wdata[SLOT_CTL_W-1:0];
    end
    assign slot_rd[s] = slot_word(ctl_q, cd_line[s]);
  end

  always_comb begin
    rd_val = '0;
    for (int unsigned i = 0; i < GP_NUM; i++)
      if (addr == gp_off(i)) rd_val = gp_rd[i];
    if (addr == OFF_MASK)  rd_val = mask_q;
    if (addr == OFF_PEND)  rd_val = pend_q;
    if (addr == OFF_SLOT0) rd_val = slot_rd[0];
    if (addr == OFF_SLOT1) rd_val = slot_rd[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_val;
  end
endmodule

// File: rtl/board_ctrl_irq.sv
module board_ctrl_irq
  import bcr_pkg::*;
#(
  parameter int unsigned N_IRQ   = 16,
  parameter int unsigned CD0_SRC = 9,
  parameter int unsigned CD1_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             irq_out
);
  // named internal events for the checker
  logic             wr_ev;
  logic             rd_ev;
  logic             mask_wr_ev;
  logic             pend_wr_ev;
  logic [N_IRQ-1:0] level_w;
  logic [DW-1:0]    mask_w;
  logic [DW-1:0]    pend_w;
  logic [1:0]       cd_w;

  assign wr_ev      = req_valid & req_write;
  assign rd_ev      = req_valid & ~req_write;
  assign mask_wr_ev = wr_ev && (req_addr == OFF_MASK);
  assign pend_wr_ev = wr_ev && (req_addr == OFF_PEND);
  assign cd_w       = {level_w[CD1_SRC], level_w[CD0_SRC]};

  bcr_sync #(.W(N_IRQ)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .level_q  (level_w)
  );

  bcr_irq_core #(.N_IRQ(N_IRQ)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (level_w),
    .wr_mask (mask_wr_ev),
    .wr_pend (pend_wr_ev),
    .wdata   (req_wdata),
    .mask_q  (mask_w),
    .pend_q  (pend_w),
    .irq_q   (irq_out)
  );

  bcr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_ev),
    .rd      (rd_ev),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .mask_q  (mask_w),
    .pend_q  (pend_w),
    .cd_line (cd_w),
    .rdata   (rsp_rdata)
  );
endmodule

// File: rtl/bcr_chk.sv
module bcr_chk
  import bcr_pkg::*;
#(
  parameter int unsigned N_IRQ = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_ev,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    rsp_rdata,
  input logic             pend_wr_ev,
  input logic [N_IRQ-1:0] level_w,
  input logic [DW-1:0]    mask_w,
  input logic [DW-1:0]    pend_w,
  input logic             irq_out
);
  logic [DW-1:0] lvl_ext;
  assign lvl_ext = DW'(level_w);

  // R3
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr_ev |=> ((pend_w & $past(lvl_ext & mask_w)) == $past(lvl_ext & mask_w)));

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr_ev |=> ((pend_w & $past(pend_w)) == $past(pend_w)));

  // R4
  write_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_w & ~IRQ_WR_PAT) == '0) && ((pend_w & ~IRQ_WR_PAT) == '0));

  // R5
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_w & mask_w)) |=> irq_out);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_w & mask_w)) |=> !irq_out);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !addr_mapped(req_addr)) |=> (rsp_rdata == '0));
endmodule

bind board_ctrl_irq bcr_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_ev      (rd_ev),
  .req_addr   (req_addr),
  .rsp_rdata  (rsp_rdata),
  .pend_wr_ev (pend_wr_ev),
  .level_w    (level_w),
  .mask_w     (mask_w),
  .pend_w     (pend_w),
  .irq_out    (irq_out)
);

// File: tb/sim_board_ctrl_irq.sv
module sim_board_ctrl_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [15:0] irq_in = '0;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctrl_irq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    check("R8 irq_out", {31'b0, irq_out}, 32'h0);
    rd(20'h000E0, d); check("R8 slot0", d, 32'h420);
    rd(20'h000E4, d); check("R8 slot1", d, 32'h420);
    rd(20'h000C0, d); check("R8 mask", d, 32'h0);
    rd(20'h000D0, d); check("R8 pending", d, 32'h0);
    rd(20'h00090, d); check("R8 misc status", d, 32'h0);
  endtask

  task automatic test_gp();
    logic [31:0] d;
    logic [19:0] offs [8] = '{20'h10, 20'h14, 20'h40, 20'h60, 20'h80, 20'h84, 20'h88, 20'h90};
    for (int i = 0; i < 8; i++) wr(offs[i], 32'hA5C3_0000 ^ (32'h1111_1111 * i) ^ 32'(i));
    for (int i = 0; i < 8; i++) begin
      rd(offs[i], d);
      check("R1 gp readback", d, 32'hA5C3_0000 ^ (32'h1111_1111 * i) ^ 32'(i));
    end
  endtask

  task automatic test_rd_timing();
    // R10: data appears the cycle after the request and holds
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h14;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 read data next cycle", rsp_rdata, 32'hA5C3_0000 ^ 32'h1111_1111 ^ 32'h1);
    req_addr = 20'h10;
    idle(2);
    check("R10 read data holds", rsp_rdata, 32'hA5C3_0000 ^ 32'h1111_1111 ^ 32'h1);
  endtask

  task automatic test_unmapped();
    logic [31:0] d;
    wr(20'h00020, 32'hDEAD_BEEF);
    wr(20'h00011, 32'h1234_5678);
    rd(20'h00020, d); check("R9 unmapped read", d, 32'h0);
    rd(20'h00010, d); check("R9 mapped word untouched", d, 32'hA5C3_0000);
    rd(20'hFFFFC, d); check("R9 high unmapped read", d, 32'h0);
  endtask

  task automatic test_pattern();
    logic [31:0] d;
    wr(20'h000C0, 32'hFFFF_FFFF);
    rd(20'h000C0, d); check("R4 mask pattern", d, 32'h000F_EEFF);
    wr(20'h000C0, 32'h0);
    wr(20'h000D0, 32'hFFFF_FFFF);
    rd(20'h000D0, d); check("R4 pending pattern", d, 32'h000F_EEFF);
    wr(20'h000D0, 32'h0);
    // line 8 cannot latch
    wr(20'h000C0, 32'h000F_FFFF);
    irq_in[8] = 1'b1;
    idle(6);
    rd(20'h000D0, d); check("R4 line 8 not latched", d, 32'h0);
    check("R4 irq_out low for line 8", {31'b0, irq_out}, 32'h0);
    irq_in[8] = 1'b0;
    wr(20'h000C0, 32'h0);
    idle(4);
  endtask

  task automatic test_latch();
    logic [31:0] d;
    irq_in[3] = 1'b1;
    idle(5);
    rd(20'h000D0, d); check("R3 masked-off line leaves pending", d, 32'h0);
    wr(20'h000C0, 32'h8);
    idle(3);
    rd(20'h000D0, d); check("R3 enabled high line latches", d, 32'h8);
    check("R5 irq_out raised", {31'b0, irq_out}, 32'h1);
    irq_in[3] = 1'b0;
    idle(5);
    rd(20'h000D0, d); check("R3 falling line keeps pending", d, 32'h8);
    check("R5 irq_out stays", {31'b0, irq_out}, 32'h1);
    wr(20'h000D0, 32'h0);
    idle(2);
    check("R5 irq_out cleared by pending write", {31'b0, irq_out}, 32'h0);
    rd(20'h000D0, d); check("R5 pending cleared", d, 32'h0);
    wr(20'h000C0, 32'h0);
  endtask

  task automatic test_sw_pending();
    logic [31:0] d;
    wr(20'h000D0, 32'h0000_0400);
    idle(2);
    check("R5 unmasked pending quiet", {31'b0, irq_out}, 32'h0);
    wr(20'h000C0, 32'h0000_0400);
    idle(2);
    check("R5 mask enables pending", {31'b0, irq_out}, 32'h1);
    wr(20'h000C0, 32'h0);
    idle(2);
    check("R5 mask removal drops output", {31'b0, irq_out}, 32'h0);
    rd(20'h000D0, d); check("R5 pending kept", d, 32'h400);
    wr(20'h000D0, 32'h0);
  endtask

  task automatic test_latency();
    wr(20'h000C0, 32'h1);
    idle(2);
    irq_in[0] = 1'b1;
    idle(3);
    check("R2 output not yet high after 3 edges", {31'b0, irq_out}, 32'h0);
    idle(1);
    check("R2 output high after 4 edges", {31'b0, irq_out}, 32'h1);
    irq_in[0] = 1'b0;
    idle(4);
    wr(20'h000D0, 32'h0);
    wr(20'h000C0, 32'h0);
    idle(2);
  endtask

  task automatic test_card();
    logic [31:0] d;
    irq_in[9] = 1'b1;
    idle(3);
    rd(20'h000E0, d); check("R6 slot0 card present", d, 32'h400);
    rd(20'h000E4, d); check("R6 slot1 unaffected by line 9", d, 32'h420);
    irq_in[13] = 1'b1;
    irq_in[9]  = 1'b0;
    idle(3);
    rd(20'h000E4, d); check("R6 slot1 card present", d, 32'h400);
    rd(20'h000E0, d); check("R6 slot0 card removed", d, 32'h420);
    irq_in[13] = 1'b0;
    idle(3);
    wr(20'h000E0, 32'hFFFF_FFFF);
    rd(20'h000E0, d); check("R7 slot0 low bits only", d, 32'h43F);
    wr(20'h000E4, 32'hFFFF_FFCA);
    rd(20'h000E4, d); check("R7 slot1 low bits only", d, 32'h42A);
    wr(20'h000E0, 32'h0);
    rd(20'h000E0, d); check("R7 slot0 low bits cleared", d, 32'h420);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    test_reset();
    test_gp();
    test_rd_timing();
    test_unmapped();
    test_pattern();
    test_latch();
    test_sw_pending();
    test_latency();
    test_card();
    finish_run();
  end
endmodule